// File: doc/BRIEF.md
# Qualified Bus Cycle Trace Recorder

This block sits beside a target processor and records its bus cycles in real time into a 256-entry circular store. Every accepted cycle keeps its address, data byte, CPU status byte and user status byte as one 40-bit entry. Once the store is full, each new entry overwrites the oldest one, so the memory always holds the most recent history.

A 4-bit qualifier code chooses which cycle types are kept: every cycle, or one of several filters on reads, writes, instruction fetches and memory versus I/O space. Each stored entry produces a one-clock sync pulse. A freeze input stops recording so the history can be read out. While frozen, the read index counts from the oldest entry. A sticky wrapped flag tells readout whether all 256 slots hold valid data or only slots 0 to `wr_ptr-1`.

Top module: `trace_capture`

## Requirements
- R1: `rd_entry` packs one stored cycle as address in bits [39:24], data in [23:16], CPU status in [15:8] and user status in [7:0].
- R2: A cycle is stored at a clock edge when `cyc_valid` is 1, the qualifier accepts it and `freeze` is 0. `wr_ptr` then advances by one, modulo 256, after that edge. Without a store, `wr_ptr` holds its value.
- R3: Qualifier codes 0 to 3 select: 0 every cycle, 1 writes (`cyc_is_write`=1), 2 reads (`cyc_is_write`=0, fetches included), 3 instruction fetches only (`cyc_is_fetch`=1, read, memory space).
- R4: Qualifier codes 4 to 8 select: 4 memory reads, 5 memory writes, 6 memory reads or writes, 7 I/O reads, 8 I/O writes. Memory space means `cyc_is_io`=0.
- R5: Qualifier codes 9 to 15 record nothing.
- R6: `sync_pulse` is high for exactly the one clock cycle that follows each edge at which an entry was stored, and is low otherwise.
- R7: The store keeps the last 256 recorded cycles. Older entries are overwritten in order.
- R8: `wrapped` rises after the 256th store, at the moment `wr_ptr` returns to 0, and stays high until reset.
- R9: While `freeze` is 1, no entry is stored. `rd_idx` is then counted from the oldest entry: index 0 is physical slot `wr_ptr` when `wrapped` is 1, and slot 0 otherwise.
- R10: While `freeze` is 0, `rd_idx` selects the physical slot directly.
- R11: After reset, `wr_ptr`, `wrapped`, `sync_pulse` and `rd_entry` are all 0.
- R12: Readout is registered: `rd_entry` shows, after an edge, the entry selected by `rd_idx` and `freeze` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_valid | input | 1 | A bus cycle is presented this clock |
| cyc_addr | input | 16 | Cycle address |
| cyc_data | input | 8 | Cycle data byte |
| cyc_cpu_st | input | 8 | CPU status byte |
| cyc_user_st | input | 8 | User-defined status byte |
| cyc_is_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cyc_is_fetch | input | 1 | Cycle is an instruction fetch |
| cyc_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| qual_sel | input | 4 | Qualifier code |
| freeze | input | 1 | Stop recording and enable oldest-relative readout |
| rd_idx | input | 8 | Read index |
| sync_pulse | output | 1 | One-clock pulse per stored entry |
| wr_ptr | output | 8 | Next slot to be written |
| wrapped | output | 1 | All 256 slots hold valid entries |
| rd_entry | output | 40 | Registered readout entry |

## Verification
The assertions assume that the cycle-type flags are used consistently: a fetch is a memory read, so `cyc_is_fetch` never comes with `cyc_is_write` or `cyc_is_io`. They also assume that `qual_sel` and `freeze` change only between clock edges. The stimulus drives only the five legal cycle kinds (memory write, memory read, fetch, I/O read, I/O write) plus idle cycles. It sets every control input half a period away from the active edge, and it clears `cyc_valid` just after each edge, so no cycle is counted twice.

// File: rtl/trace_pkg.sv
`timescale 1ns/1ps
package trace_pkg;

  localparam int QSEL_W = 4;
  localparam int NCODES = 1 << QSEL_W;

  typedef enum logic [QSEL_W-1:0] {
    Q_ALL    = 4'd0,
    Q_WR     = 4'd1,
    Q_RD     = 4'd2,
    Q_FETCH  = 4'd3,
    Q_MEM_RD = 4'd4,
    Q_MEM_WR = 4'd5,
    Q_MEM_RW = 4'd6,
    Q_IO_RD  = 4'd7,
    Q_IO_WR  = 4'd8
  } qual_e;

  typedef struct packed {
    logic is_write;
    logic is_fetch;
    logic is_io;
  } cyc_kind_t;

  // One bit per qualifier code; codes without a class stay 0.
  function automatic logic [NCODES-1:0] class_hits(cyc_kind_t k);
    logic [NCODES-1:0] h;
    logic rd;
    logic mem;
    rd  = !k.is_write;
    mem = !k.is_io;
    h = '0;
    h[int'(Q_ALL)]    = 1'b1;
    h[int'(Q_WR)]     = k.is_write;
    h[int'(Q_RD)]     = rd;
    h[int'(Q_FETCH)]  = k.is_fetch & rd & mem;
    h[int'(Q_MEM_RD)] = rd & mem;
    h[int'(Q_MEM_WR)] = k.is_write & mem;
    h[int'(Q_MEM_RW)] = mem;
    h[int'(Q_IO_RD)]  = rd & k.is_io;
    h[int'(Q_IO_WR)]  = k.is_write & k.is_io;
    return h;
  endfunction

  function automatic logic qual_match(logic [QSEL_W-1:0] sel, cyc_kind_t k);
    logic [NCODES-1:0] h;
    h = class_hits(k);
    return h[sel];
  endfunction

endpackage

// File: rtl/trace_qualifier.sv
`timescale 1ns/1ps
module trace_qualifier
  import trace_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  cyc_kind_t         kind,
  input  logic [QSEL_W-1:0] qual_sel,
  input  logic              freeze,
  output logic              store_hit
);

  logic type_ok;

  always_comb begin
    type_ok   = qual_match(qual_sel, kind);
    store_hit = cyc_valid & type_ok & !freeze;
  end

  // R5: codes above the last defined filter never store
  p_unused_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_sel > 4'd8) |-> !store_hit);

  // R9: a frozen recorder accepts nothing
  p_frozen_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !store_hit);

endmodule

// File: rtl/trace_store.sv
`timescale 1ns/1ps
module trace_store #(
  parameter int EW         = 40,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [EW-1:0]         wr_data,
  input  logic [DEPTH_LOG2-1:0] rd_slot,
  output logic [DEPTH_LOG2-1:0] wr_ptr,
  output logic                  wrapped,
  output logic                  sync_pulse,
  output logic [EW-1:0]         rd_data
);

  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [EW-1:0] mem [DEPTH];
  logic          last_slot;

  assign last_slot = (wr_ptr == {DEPTH_LOG2{1'b1}});

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      wrapped    <= 1'b0;
      sync_pulse <= 1'b0;
      rd_data    <= '0;
    end else begin
      sync_pulse <= wr_en;
      rd_data    <= mem[rd_slot];
      if (wr_en) begin
        wr_ptr <= wr_ptr + 1'b1;
        if (last_slot) wrapped <= 1'b1;
      end
    end
  end

  // R2: pointer moves by exactly one per store
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_ptr == $past(wr_ptr) + 1'b1));

  // R2: pointer rests without a store
  p_ptr_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_ptr));

  // R6: pulse follows a store and nothing else
  p_sync_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> (wr_ptr == $past(wr_ptr) + 1'b1));

  // R8: wrapped never clears
  p_wrap_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |=> wrapped);

  // R8: wrapped rises only as the pointer returns to slot 0
  p_wrap_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrapped) |-> (wr_ptr == '0) && sync_pulse);

endmodule

// File: rtl/trace_reader.sv
`timescale 1ns/1ps
module trace_reader #(
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                  freeze,
  input  logic                  wrapped,
  input  logic [DEPTH_LOG2-1:0] wr_ptr,
  input  logic [DEPTH_LOG2-1:0] rd_idx,
  output logic [DEPTH_LOG2-1:0] rd_slot
);

  // Oldest entry lives at the write pointer once the ring has wrapped.
  function automatic logic [DEPTH_LOG2-1:0] map_slot(
    logic frz, logic wrp, logic [DEPTH_LOG2-1:0] base, logic [DEPTH_LOG2-1:0] idx);
    if (frz && wrp) return base + idx;
    return idx;
  endfunction

  assign rd_slot = map_slot(freeze, wrapped, wr_ptr, rd_idx);

endmodule

// File: rtl/trace_capture.sv
`timescale 1ns/1ps
module trace_capture
  import trace_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int CW         = 8,
  parameter int UW         = 8,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cyc_valid,
  input  logic [AW-1:0]         cyc_addr,
  input  logic [DW-1:0]         cyc_data,
  input  logic [CW-1:0]         cyc_cpu_st,
  input  logic [UW-1:0]         cyc_user_st,
  input  logic                  cyc_is_write,
  input  logic                  cyc_is_fetch,
  input  logic                  cyc_is_io,
  input  logic [QSEL_W-1:0]     qual_sel,
  input  logic                  freeze,
  input  logic [DEPTH_LOG2-1:0] rd_idx,
  output logic                  sync_pulse,
  output logic [DEPTH_LOG2-1:0] wr_ptr,
  output logic                  wrapped,
  output logic [AW+DW+CW+UW-1:0] rd_entry
);

  localparam int EW = AW + DW + CW + UW;

  cyc_kind_t             kind;
  logic                  store_hit;
  logic [EW-1:0]         entry_in;
  logic [DEPTH_LOG2-1:0] rd_slot;

  assign kind     = '{is_write: cyc_is_write, is_fetch: cyc_is_fetch, is_io: cyc_is_io};
  // R1: address, data, CPU status, user status from high to low bits
  assign entry_in = {cyc_addr, cyc_data, cyc_cpu_st, cyc_user_st};

  trace_qualifier u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_valid (cyc_valid),
    .kind      (kind),
    .qual_sel  (qual_sel),
    .freeze    (freeze),
    .store_hit (store_hit)
  );

  trace_store #(.EW(EW), .DEPTH_LOG2(DEPTH_LOG2)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (store_hit),
    .wr_data    (entry_in),
    .rd_slot    (rd_slot),
    .wr_ptr     (wr_ptr),
    .wrapped    (wrapped),
    .sync_pulse (sync_pulse),
    .rd_data    (rd_entry)
  );

  trace_reader #(.DEPTH_LOG2(DEPTH_LOG2)) u_read (
    .freeze  (freeze),
    .wrapped (wrapped),
    .wr_ptr  (wr_ptr),
    .rd_idx  (rd_idx),
    .rd_slot (rd_slot)
  );

  // R2: an idle bus produces no pulse
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> !sync_pulse);

  // R9: freezing holds the pointer
  p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(wr_ptr) && !sync_pulse);

endmodule

// File: tb/trace_capture_bench.sv
`timescale 1ns/1ps
module trace_capture_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic [15:0] cyc_addr = '0;
  logic [7:0]  cyc_data = '0, cyc_cpu_st = '0, cyc_user_st = '0;
  logic        cyc_is_write = 1'b0, cyc_is_fetch = 1'b0, cyc_is_io = 1'b0;
  logic [3:0]  qual_sel = '0;
  logic        freeze = 1'b0;
  logic [7:0]  rd_idx = '0;
  logic        sync_pulse;
  logic [7:0]  wr_ptr;
  logic        wrapped;
  logic [39:0] rd_entry;

  trace_capture u_trace_capture (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
    .cyc_data(cyc_data), .cyc_cpu_st(cyc_cpu_st), .cyc_user_st(cyc_user_st),
    .cyc_is_write(cyc_is_write), .cyc_is_fetch(cyc_is_fetch), .cyc_is_io(cyc_is_io),
    .qual_sel(qual_sel), .freeze(freeze), .rd_idx(rd_idx),
    .sync_pulse(sync_pulse), .wr_ptr(wr_ptr), .wrapped(wrapped), .rd_entry(rd_entry)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int seq    = 0;
  int total  = 0;
  logic [7:0]  ptr_m = '0;
  logic [39:0] hist[$];
  logic [39:0] phys [256];

  // scoreboard queues
  bit         q_hit[$];
  logic [7:0] q_ptr[$];
  bit         q_wrap[$];
  string      q_tag[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent statement of the qualifier table (R3, R4, R5)
  function automatic bit exp_match(input logic [3:0] m, input bit w, input bit f, input bit io);
    case (m)
      4'd0: return 1'b1;
      4'd1: return w;
      4'd2: return !w;
      4'd3: return f && !w && !io;
      4'd4: return !w && !io;
      4'd5: return w && !io;
      4'd6: return !io;
      4'd7: return !w && io;
      4'd8: return w && io;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(input bit v, input bit w, input bit f, input bit io, input string tag);
    bit hit;
    logic [39:0] e;
    @(negedge clk);
    seq++;
    cyc_addr     = 16'h1000 + 16'(seq * 7);
    cyc_data     = 8'(seq) ^ 8'h5A;
    cyc_cpu_st   = ~8'(seq);
    cyc_user_st  = 8'(seq * 3);
    cyc_valid    = v;
    cyc_is_write = w;
    cyc_is_fetch = f;
    cyc_is_io    = io;
    e = {cyc_addr, cyc_data, cyc_cpu_st, cyc_user_st};
    hit = v && !freeze && exp_match(qual_sel, w, f, io);
    if (hit) begin
      phys[ptr_m] = e;
      hist.push_back(e);
      if (hist.size() > 256) void'(hist.pop_front());
      ptr_m++;
      total++;
    end
    q_hit.push_back(hit);
    q_ptr.push_back(ptr_m);
    q_wrap.push_back(total >= 256);
    q_tag.push_back(tag);
    @(posedge clk);
    #1 cyc_valid = 1'b0;
  endtask

  // monitor: compare pulse, pointer and wrapped flag after each driven edge
  bit         m_hit, m_wrap;
  logic [7:0] m_ptr;
  string      m_tag;
  always @(posedge clk) begin
    #2;
    if (q_hit.size() > 0) begin
      m_hit  = q_hit.pop_front();
      m_ptr  = q_ptr.pop_front();
      m_wrap = q_wrap.pop_front();
      m_tag  = q_tag.pop_front();
      chk(sync_pulse === m_hit, {m_tag, " R6 sync"}, 64'(sync_pulse), 64'(m_hit));
      chk(wr_ptr === m_ptr, {m_tag, " R2 wr_ptr"}, 64'(wr_ptr), 64'(m_ptr));
      chk(wrapped === m_wrap, "R8 wrapped", 64'(wrapped), 64'(m_wrap));
    end
  end

  task automatic read_at(input logic [7:0] idx, input logic [39:0] exp, input string tag);
    @(negedge clk);
    rd_idx = idx;
    @(posedge clk);
    #2;
    chk(rd_entry === exp, tag, 64'(rd_entry), 64'(exp));
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk);
    qual_sel = m;
  endtask

  int cyc_count = 0;
  always @(posedge clk) begin
    cyc_count++;
    if (cyc_count > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(wr_ptr === 8'd0, "R11 wr_ptr", 64'(wr_ptr), 0);
    chk(wrapped === 1'b0, "R11 wrapped", 64'(wrapped), 0);
    chk(sync_pulse === 1'b0, "R11 sync", 64'(sync_pulse), 0);
    chk(rd_entry === 40'd0, "R11 rd_entry", 64'(rd_entry), 0);
    rst_n = 1'b1;

    // R2/R6: record-all mode with idle gaps and back-to-back cycles
    set_mode(4'd0);
    drive(1, 0, 1, 0, "R2");
    drive(1, 1, 0, 0, "R2");
    drive(0, 0, 0, 0, "R2 idle");
    drive(1, 0, 0, 1, "R2");
    drive(1, 1, 0, 1, "R2");
    drive(0, 1, 0, 0, "R2 idle");
    drive(1, 0, 0, 0, "R2");
    drive(1, 1, 0, 0, "R2");

    // R9: frozen cycles are not stored; R1/R12 oldest-relative readout
    @(negedge clk) freeze = 1'b1;
    drive(1, 0, 0, 0, "R9 frozen");
    drive(1, 1, 0, 0, "R9 frozen");
    for (int i = 0; i < hist.size(); i++)
      read_at(8'(i), hist[i], "R1 R9 R12 frozen read");

    // R10: unfrozen physical read (not wrapped, slot equals order)
    @(negedge clk) freeze = 1'b0;
    read_at(8'd3, phys[3], "R10 physical read");

    // R3 / R4 / R5: every code against the five cycle kinds
    for (int m = 0; m < 16; m++) begin
      string t;
      t = (m <= 3) ? "R3" : ((m <= 8) ? "R4" : "R5");
      set_mode(4'(m));
      drive(1, 1, 0, 0, t);
      drive(1, 0, 0, 0, t);
      drive(1, 0, 1, 0, t);
      drive(1, 0, 0, 1, t);
      drive(1, 1, 0, 1, t);
      drive(0, 0, 1, 0, t);
    end

    // R8: fill up to the wrap boundary
    set_mode(4'd0);
    while (total < 255) drive(1, total % 2 == 1, 0, total % 3 == 0, "R7 fill");
    @(negedge clk);
    chk(wrapped === 1'b0, "R8 before 256th", 64'(wrapped), 0);
    drive(1, 0, 0, 0, "R8 256th");
    @(negedge clk);
    chk(wrapped === 1'b1, "R8 after 256th", 64'(wrapped), 1);
    chk(wr_ptr === 8'd0, "R8 ptr at wrap", 64'(wr_ptr), 0);

    // R7: overwrite oldest
    for (int k = 0; k < 41; k++) drive(1, k % 2 == 0, 0, 0, "R7 overwrite");

    @(negedge clk) freeze = 1'b1;
    for (int i = 0; i < 256; i++)
      read_at(8'(i), hist[i], "R7 R9 wrapped frozen read");

    @(negedge clk) freeze = 1'b0;
    for (int s = 0; s < 4; s++)
      read_at(8'(s), phys[s], "R10 physical after wrap");

    repeat (3) @(posedge clk);
    #3;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule